// File: doc/BRIEF.md
# Iterative AES-128 Decryption Engine

This block runs the AES-128 inverse cipher on one 128-bit ciphertext block. It completes one round per clock cycle. It holds no key storage of its own. It drives an address to an external round-key memory, which is shared with a key-expansion unit elsewhere, and it consumes the 128-bit key that the memory returns one cycle later. The memory is walked from index 10 down to index 0.

A parent controller places a ciphertext on the data input and pulses the start strobe. The engine first spends one cycle letting the key memory produce key 10. It then whitens the captured block with that key. Ten rounds follow, each applying the inverse row shift, the inverse byte substitution, the round-key addition and the inverse column mix, in that order. The last round, which uses key 0, leaves out the inverse column mix. When the result is ready it is written into an output register and a one-cycle done pulse is raised. The parent can accept the plaintext on that pulse and may start the next block in the same cycle.

Byte convention: byte 0 of a block or key sits in bits 127:120 and byte 15 in bits 7:0. The state is filled column by column, so byte `4*c + r` is row `r`, column `c`.

Top module: `aes128_dec_iter`

## Requirements
- R1: While reset is high and in the first idle cycle after it, `done_o` is 0, `key_addr_o` is 10 and `pt_o` is all zeros.
- R2: In idle, `key_addr_o` is 10. After a start is accepted it stays at 10 for one more cycle, then steps down by one per cycle from 9 to 0, holds 0 during the final round, and is back at 10 in the done cycle.
- R3: `done_o` is high for exactly one cycle. It rises 12 rising edges after the edge that samples the accepted start, so it is visible in the 13th cycle counted from the start cycle. No done is produced without an accepted start.
- R4: The round-key memory returns key k one cycle after address k is presented. Under that condition `pt_o` equals the AES-128 inverse cipher of the accepted ciphertext, with byte 0 in bits 127:120. Key 10 is applied first with no transform before it, and the last round uses key 0 and omits the inverse column mix. For key 000102..0f, ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a gives 00112233445566778899aabbccddeeff.
- R5: For any key and plaintext, decrypting the AES-128 forward-cipher output of that plaintext returns the original plaintext. This includes the all-zero and all-one blocks.
- R6: A start pulse while an operation is in progress is ignored. The running result, its done timing and the count of done pulses are unchanged.
- R7: `ct_i` is sampled only on the edge that accepts the start. Changing it afterwards does not alter the result.
- R8: `pt_o` keeps its value from one done pulse until the next.
- R9: A start asserted in the cycle where `done_o` is high is accepted, so blocks can follow each other every 13 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, honoured only when idle |
| ct_i | input | 128 | Ciphertext block |
| key_addr_o | output | 4 | Round-key memory read address |
| round_key_i | input | 128 | Round key from memory, one cycle after the address |
| pt_o | output | 128 | Registered plaintext result |
| done_o | output | 1 | One-cycle pulse: `pt_o` has just been updated |

## Verification
The case hardest to reach from the ports is a start landing exactly in the done cycle. It has to be accepted while the previous result is being handed over, and the counter has to be reloaded to 10 on the same edge. The bench reaches it by chaining blocks with the next start issued precisely 13 cycles after the previous one. The scoreboard then checks both the data and the cycle on which each done appears. A second hard case is a stray start in mid-operation. It is injected several cycles after a legal start with a different ciphertext, and the bench then watches for any extra done pulse during a long idle window afterwards.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WAIT  = 2'd1,
    S_INIT  = 2'd2,
    S_ROUND = 2'd3
  } dec_state_e;

  // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int k);
    return (v << k) | (v >> (8 - k));
  endfunction

  // forward substitution: field inverse (x^254) followed by the affine map
  function automatic logic [7:0] fwd_sbox(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] inv;
    sq  = x;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  // inverse substitution table, built by inverting the forward mapping
  function automatic logic [2047:0] inv_sbox_table();
    logic [2047:0] t;
    logic [7:0]    s;
    t = '0;
    for (int v = 0; v < 256; v++) begin
      s = fwd_sbox(v[7:0]);
      t[int'(s)*8 +: 8] = v[7:0];
    end
    return t;
  endfunction

endpackage

// File: rtl/aes_inv_sbox.sv
module aes_inv_sbox (
  input  logic [7:0] a_i,
  output logic [7:0] y_o
);
  localparam logic [2047:0] TBL = aes_dec_pkg::inv_sbox_table();

  assign y_o = TBL[{a_i, 3'b000} +: 8];
endmodule

// File: rtl/aes_inv_mixcol.sv
module aes_inv_mixcol (
  input  logic [31:0] col_i,
  output logic [31:0] col_o
);
  import aes_dec_pkg::gf_mul;

  logic [7:0] a0, a1, a2, a3;
  assign a0 = col_i[31:24];
  assign a1 = col_i[23:16];
  assign a2 = col_i[15:8];
  assign a3 = col_i[7:0];

  always_comb begin
    col_o[31:24] = gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
    col_o[23:16] = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
    col_o[15:8]  = gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
    col_o[7:0]   = gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
  end
endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round #(
  parameter int BLK = 128
) (
  input  logic [BLK-1:0] state_i,
  input  logic [BLK-1:0] key_i,
  input  logic           last_i,
  output logic [BLK-1:0] state_o
);
  localparam int NB   = BLK / 8;
  localparam int NCOL = NB / 4;

  logic [BLK-1:0] shifted;
  logic [BLK-1:0] subbed;
  logic [BLK-1:0] keyed;
  logic [BLK-1:0] mixed;

  // inverse row shift: row r rotates right by r columns, then substitution
  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int ROW = b % 4;
    localparam int COL = b / 4;
    localparam int SRC = ROW + 4 * ((COL - ROW + NCOL) % NCOL);

    assign shifted[BLK-1-8*b -: 8] = state_i[BLK-1-8*SRC -: 8];

    aes_inv_sbox u_sbox (
      .a_i (shifted[BLK-1-8*b -: 8]),
      .y_o (subbed[BLK-1-8*b -: 8])
    );
  end

  assign keyed = subbed ^ key_i;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    aes_inv_mixcol u_mix (
      .col_i (keyed[BLK-1-32*c -: 32]),
      .col_o (mixed[BLK-1-32*c -: 32])
    );
  end

  // final round bypasses the column mix
  assign state_o = last_i ? keyed : mixed;
endmodule

// File: rtl/aes_dec_ctrl.sv
module aes_dec_ctrl #(
  parameter int NROUNDS = 10,
  localparam int AW = $clog2(NROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic [AW-1:0] addr_o,
  output logic          cap_o,
  output logic          init_o,
  output logic          rnd_o,
  output logic          last_o
);
  import aes_dec_pkg::*;

  localparam logic [AW-1:0] TOP_IDX = AW'(NROUNDS);

  dec_state_e    st_q;
  logic [AW-1:0] cnt_q;
  logic          fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_IDLE;
      cnt_q <= TOP_IDX;
      fin_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start_i) begin
            st_q  <= S_WAIT;
            cnt_q <= TOP_IDX;
          end
        end
        S_WAIT: begin
          st_q  <= S_INIT;
          cnt_q <= cnt_q - AW'(1);
        end
        S_INIT: begin
          st_q  <= S_ROUND;
          cnt_q <= cnt_q - AW'(1);
        end
        default: begin
          if (fin_q) begin
            st_q  <= S_IDLE;
            cnt_q <= TOP_IDX;
            fin_q <= 1'b0;
          end else if (cnt_q == '0) begin
            fin_q <= 1'b1;            // early flag: next round is the last
          end else begin
            cnt_q <= cnt_q - AW'(1);
          end
        end
      endcase
    end
  end

  assign addr_o = cnt_q;
  assign cap_o  = (st_q == S_IDLE) && start_i;
  assign init_o = (st_q == S_INIT);
  assign rnd_o  = (st_q == S_ROUND);
  assign last_o = fin_q;

  // R1/R2: idle presents the top key index
  a_r2_idle_top_index: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE) |-> (addr_o == TOP_IDX));

  // R2: address steps down by one while walking the memory
  a_r2_addr_descends: assert property (@(posedge clk) disable iff (rst)
    ((st_q == S_WAIT) || (st_q == S_INIT) || ((st_q == S_ROUND) && (cnt_q != '0)))
      |=> (cnt_q == $past(cnt_q) - AW'(1)));

  // R3: final-round flag only with the address parked at zero
  a_r3_last_at_zero: assert property (@(posedge clk) disable iff (rst)
    fin_q |-> ((st_q == S_ROUND) && (cnt_q == '0)));

  // R6: a start during an operation never restarts it
  a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    ((st_q != S_IDLE) && start_i) |=> (st_q != S_WAIT));
endmodule

// File: rtl/aes128_dec_iter.sv
module aes128_dec_iter #(
  parameter int BLK     = 128,
  parameter int NROUNDS = 10,
  localparam int AW = $clog2(NROUNDS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [BLK-1:0] ct_i,
  output logic [AW-1:0]  key_addr_o,
  input  logic [BLK-1:0] round_key_i,
  output logic [BLK-1:0] pt_o,
  output logic           done_o
);
  logic           cap;
  logic           init;
  logic           rnd;
  logic           last;
  logic [BLK-1:0] state_q;
  logic [BLK-1:0] round_out;
  logic [BLK-1:0] res_q;
  logic           done_q;

  aes_dec_ctrl #(.NROUNDS(NROUNDS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .addr_o  (key_addr_o),
    .cap_o   (cap),
    .init_o  (init),
    .rnd_o   (rnd),
    .last_o  (last)
  );

  aes_inv_round #(.BLK(BLK)) u_round (
    .state_i (state_q),
    .key_i   (round_key_i),
    .last_i  (last),
    .state_o (round_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (cap) begin
      state_q <= ct_i;
    end else if (init) begin
      state_q <= state_q ^ round_key_i;   // whitening with the top key
    end else if (rnd) begin
      state_q <= round_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= rnd && last;
      if (rnd && last) res_q <= round_out;
    end
  end

  assign pt_o   = res_q;
  assign done_o = done_q;

  // R3: done lasts one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R8: result only moves together with a done pulse
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(res_q));
endmodule

// File: tb/aes128_dec_iter_test.sv
`timescale 1ns/1ps
module aes128_dec_iter_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] din = '0;
  logic [3:0]   key_addr;
  logic [127:0] rk = '0;
  logic [127:0] pt;
  logic         done;

  int n_chk = 0;
  int n_fail = 0;
  int n_unexp = 0;
  int cyc = 0;

  logic [127:0] km [0:10];
  logic [127:0] q_pt [$];
  int           q_due [$];
  string        q_tag [$];

  always #2.5 clk = ~clk;

  aes128_dec_iter uut (
    .clk (clk), .rst (rst), .start_i (start), .ct_i (din),
    .key_addr_o (key_addr), .round_key_i (rk), .pt_o (pt), .done_o (done)
  );

  // synchronous-read key memory model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rk  <= (key_addr <= 4'd10) ? km[key_addr] : '0;
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] inv = 8'h01;
    logic [7:0] r;
    for (int i = 0; i < 254; i++) inv = m_mul(inv, x);
    r = inv;
    for (int k = 1; k < 5; k++) r ^= (inv << k) | (inv >> (8 - k));
    return r ^ 8'h63;
  endfunction

  task automatic load_key(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {m_sbox(t[23:16]), m_sbox(t[15:8]), m_sbox(t[7:0]), m_sbox(t[31:24])} ^ {rc, 24'h0};
        rc = m_mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int k = 0; k < 11; k++) km[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
  endtask

  function automatic logic [127:0] enc_block(input logic [127:0] p);
    logic [127:0] s;
    logic [127:0] u;
    logic [7:0]   a0, a1, a2, a3;
    s = p ^ km[0];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int b = 0; b < 16; b++) s[127-8*b -: 8] = m_sbox(s[127-8*b -: 8]);
      for (int b = 0; b < 16; b++) u[127-8*b -: 8] = s[127-8*((b % 4) + 4*(((b / 4) + (b % 4)) % 4)) -: 8];
      s = u;
      if (rd != 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = s[127-32*c -: 8]; a1 = s[119-32*c -: 8]; a2 = s[111-32*c -: 8]; a3 = s[103-32*c -: 8];
          u[127-32*c -: 8] = m_mul(a0, 2) ^ m_mul(a1, 3) ^ a2 ^ a3;
          u[119-32*c -: 8] = a0 ^ m_mul(a1, 2) ^ m_mul(a2, 3) ^ a3;
          u[111-32*c -: 8] = a0 ^ a1 ^ m_mul(a2, 2) ^ m_mul(a3, 3);
          u[103-32*c -: 8] = m_mul(a0, 3) ^ a1 ^ a2 ^ m_mul(a3, 2);
        end
        s = u;
      end
      s ^= km[rd];
    end
    return s;
  endfunction

  // ---------------- driver ----------------
  task automatic issue(input logic [127:0] ct, input logic [127:0] exp_pt, input string tag);
    start = 1'b1;
    din   = ct;
    q_pt.push_back(exp_pt);
    q_due.push_back(cyc + 13);
    q_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (q_pt.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (q_pt.size() == 0) begin
          n_unexp++;
          chk(1'b0, "R3 done without accepted start", pt, '0);
        end else begin
          chk(pt == q_pt[0], q_tag[0], pt, q_pt[0]);
          chk(cyc == q_due[0], "R3 done latency", 128'(cyc), 128'(q_due[0]));
          void'(q_pt.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
        end
      end else if (q_pt.size() != 0 && cyc > q_due[0]) begin
        chk(1'b0, "R3 done missing", 128'(cyc), 128'(q_due[0]));
        void'(q_pt.pop_front()); void'(q_due.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [127:0] key, p, c, hold;
    for (int k = 0; k < 11; k++) km[k] = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0, "R1 done in reset", 128'(done), 0);
    chk(key_addr == 4'd10, "R1 addr in reset", 128'(key_addr), 128'd10);
    chk(pt == '0, "R1 pt in reset", pt, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && key_addr == 4'd10 && pt == '0, "R1 first idle cycle", pt, '0);

    // R4: published vector A, with R2 address walk
    load_key(128'h000102030405060708090a0b0c0d0e0f);
    chk(enc_block(128'h00112233445566778899aabbccddeeff) == 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
        "R4 bench model vector A", enc_block(128'h00112233445566778899aabbccddeeff),
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    issue(128'h69c4e0d86a7b0430d8cdb78070b4c55a, 128'h00112233445566778899aabbccddeeff, "R4 vector A");
    for (int k = 0; k <= 10; k++) begin
      chk(key_addr == 4'(10 - k), "R2 address walk", 128'(key_addr), 128'(10 - k));
      @(negedge clk);
    end
    chk(key_addr == 4'd0, "R2 address held in final round", 128'(key_addr), 0);
    drain();
    // R8: output holds while idle, R2: address back at top
    for (int k = 0; k < 5; k++) begin
      chk(pt == 128'h00112233445566778899aabbccddeeff, "R8 result hold", pt,
          128'h00112233445566778899aabbccddeeff);
      chk(key_addr == 4'd10, "R2 idle address", 128'(key_addr), 128'd10);
      @(negedge clk);
    end

    // R4: published vector B
    load_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
    issue(128'h3925841d02dc09fbdc118597196a0b32, 128'h3243f6a8885a308d313198a2e0370734, "R4 vector B");
    drain();

    // R5: round trip under several keys
    for (int kk = 0; kk < 3; kk++) begin
      key = {$urandom, $urandom, $urandom, $urandom};
      load_key(key);
      for (int j = 0; j < 5; j++) begin
        p = (j == 0) ? '0 : (j == 1) ? '1 : {$urandom, $urandom, $urandom, $urandom};
        issue(enc_block(p), p, "R5 round trip");
        drain();
      end
    end

    // R9: back-to-back blocks, next start in the done cycle
    p = {$urandom, $urandom, $urandom, $urandom};
    issue(enc_block(p), p, "R9 chained block 1");
    repeat (12) @(negedge clk);
    p = ~p;
    issue(enc_block(p), p, "R9 chained block 2");
    repeat (12) @(negedge clk);
    p = p ^ 128'h0123456789abcdef0123456789abcdef;
    issue(enc_block(p), p, "R9 chained block 3");
    drain();

    // R6: stray start mid-operation is ignored
    p = {$urandom, $urandom, $urandom, $urandom};
    issue(enc_block(p), p, "R6 result unaffected by stray start");
    repeat (4) @(negedge clk);
    start = 1'b1;
    din = enc_block(~p);
    @(negedge clk);
    start = 1'b0;
    drain();
    hold = pt;
    repeat (20) @(negedge clk);
    chk(n_unexp == 0, "R6 no extra done", 128'(n_unexp), 0);
    chk(pt == hold, "R8 hold after stray start", pt, hold);

    // R7: ciphertext input changes after acceptance
    p = {$urandom, $urandom, $urandom, $urandom};
    c = enc_block(p);
    issue(c, p, "R7 input sampled only at start");
    for (int k = 0; k < 11; k++) begin
      din = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
    end
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule